// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers single-cycle event pulses from a network controller's receive, transmit, link, overflow and system-error logic into a 16-bit sticky status register. A companion 16-bit mask register selects which pending bits may drive one level-sensitive interrupt line. Software clears a pending bit by writing a one to it. Writing a zero to a status bit leaves it as it is.

Two sources live inside the block. The first is a software-forced interrupt, raised by writing bit 0 of a poll register. The second is a free-running cycle counter with a compare register that raises a timeout event. A small state machine arms the timer only while the compare value is nonzero. It has two states: `T_IDLE` (compare is zero, so no timeout) and `T_ARMED` (compare is nonzero). Two transitions connect them. `arm` moves `T_IDLE` to `T_ARMED` on a compare write with nonzero data. `disarm` moves `T_ARMED` to `T_IDLE` on a compare write with zero data. Every other cycle holds the current state.

Registers are reached over a plain single-cycle write bus with a combinational read port, addressed by byte offset. The offsets are: poll 0x38, mask 0x3C, status 0x3E, count 0x48, compare 0x58. Any other address reads as zero.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, status, mask, count and compare read as zero and `irq` is low.
- R2: A pulse on `hw_event[i]` (i = 0..7) sets status bit i on the next clock edge. `sys_err` sets bit 15. Status bits 9 to 13 always read zero. The other bits carry these events: bit 0 receive ok, bit 1 receive error, bit 2 transmit ok, bit 3 transmit error, bit 4 receive descriptor unavailable, bit 5 underrun or link change, bit 6 receive FIFO overflow, bit 7 transmit descriptor unavailable.
- R3: A write to status (0x3E) clears every bit whose data bit is one and leaves bits written with zero unchanged.
- R4: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: `irq` is high exactly when some status bit and its mask bit (mask at 0x3C, bit i masks status bit i) are both one. Status bits latch while masked, and unmasking a pending bit raises `irq` right after the mask write.
- R6: A write to the poll register (0x38) with data bit 0 set sets status bit 8. With data bit 0 clear, the write has no effect.
- R7: The count register (0x48) increments by one every cycle. Any write to it, whatever the data, makes it read zero after that edge.
- R8: With a nonzero compare value (0x58), status bit 14 is set on the edge after the count equals the compare value. In terms of the count write: count writes at edge E, count reads C after edge E+C, and bit 14 is set after edge E+C+1.
- R9: With a compare value of zero, status bit 14 is never set by the timer.
- R10: Mask and compare read back the value last written. Mask uses data bits 15:0 and compare uses the full data word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| hw_event | input | 8 | Event pulses for status bits 7..0 |
| sys_err | input | 1 | System error pulse for status bit 15 |
| irq | output | 1 | Level interrupt, OR of status AND mask |

## Verification
The bench targets a clearing write that lands in the same cycle as the event it would erase. A design that lets the clear win would silently drop an interrupt. It also checks that a masked bit keeps latching, so unmasking it raises `irq` at once; a design that gated the latch with the mask would lose that event. The timer is checked on the exact cycle of its compare match, and again with compare zero, where a design that compared against zero would fire once per wrap. Write-zero and poll-with-bit-0-clear writes are checked for leaving status untouched, against a reference model driven by long random mixes of events and writes.

// File: rtl/isc_pkg.sv
package isc_pkg;
    localparam int STAT_W = 16;

    localparam logic [7:0] OFS_POLL   = 8'h38;
    localparam logic [7:0] OFS_MASK   = 8'h3C;
    localparam logic [7:0] OFS_STATUS = 8'h3E;
    localparam logic [7:0] OFS_COUNT  = 8'h48;
    localparam logic [7:0] OFS_CMP    = 8'h58;

    localparam int BIT_SWINT   = 8;
    localparam int BIT_TIMEOUT = 14;
    localparam int BIT_SYSERR  = 15;

    typedef enum logic [0:0] {
        T_IDLE  = 1'b0,
        T_ARMED = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/isc_regif.sv
module isc_regif
    import isc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int TMR_W  = 32
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [STAT_W-1:0] status_q,
    input  logic [STAT_W-1:0] mask_q,
    input  logic [TMR_W-1:0]  cnt_q,
    input  logic [TMR_W-1:0]  cmp_q,
    output logic [STAT_W-1:0] stat_clr,
    output logic              mask_we,
    output logic              poll_sw,
    output logic              cnt_we,
    output logic              cmp_we,
    output logic [DATA_W-1:0] bus_rdata
);
    logic hit_poll, hit_mask, hit_stat, hit_cnt, hit_cmp;

    always_comb begin
        hit_poll = (bus_addr == ADDR_W'(OFS_POLL));
        hit_mask = (bus_addr == ADDR_W'(OFS_MASK));
        hit_stat = (bus_addr == ADDR_W'(OFS_STATUS));
        hit_cnt  = (bus_addr == ADDR_W'(OFS_COUNT));
        hit_cmp  = (bus_addr == ADDR_W'(OFS_CMP));
    end

    always_comb begin
        stat_clr = (bus_wr && hit_stat) ? bus_wdata[STAT_W-1:0] : '0;
        mask_we  = bus_wr && hit_mask;
        poll_sw  = bus_wr && hit_poll && bus_wdata[0];
        cnt_we   = bus_wr && hit_cnt;
        cmp_we   = bus_wr && hit_cmp;
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_mask)      bus_rdata = DATA_W'(mask_q);
        else if (hit_stat) bus_rdata = DATA_W'(status_q);
        else if (hit_cnt)  bus_rdata = DATA_W'(cnt_q);
        else if (hit_cmp)  bus_rdata = DATA_W'(cmp_q);
    end
endmodule

// File: rtl/isc_timer.sv
module isc_timer
    import isc_pkg::*;
#(
    parameter int TMR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_we,
    input  logic             cmp_we,
    input  logic [TMR_W-1:0] cmp_wdata,
    output logic [TMR_W-1:0] cnt_q,
    output logic [TMR_W-1:0] cmp_q,
    output logic             timeout_evt
);
    tmr_state_e state_q, state_d;

    // free-running count, cleared by any write
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_we) cnt_q <= '0;
        else             cnt_q <= cnt_q + TMR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '0;
        else if (cmp_we) cmp_q <= cmp_wdata;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= T_IDLE;
        else        state_q <= state_d;
    end

    // next state: arm / disarm on compare writes
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_IDLE:  if (cmp_we && (cmp_wdata != '0)) state_d = T_ARMED;
            T_ARMED: if (cmp_we && (cmp_wdata == '0)) state_d = T_IDLE;
            default: state_d = T_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        timeout_evt = 1'b0;
        unique case (state_q)
            T_IDLE:  timeout_evt = 1'b0;
            T_ARMED: timeout_evt = (cnt_q == cmp_q);
            default: timeout_evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/isc_status.sv
module isc_status
    import isc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] ev_set,
    input  logic [STAT_W-1:0] stat_clr,
    input  logic              mask_we,
    input  logic [STAT_W-1:0] mask_wdata,
    output logic [STAT_W-1:0] status_q,
    output logic [STAT_W-1:0] mask_q,
    output logic              irq
);
    // one sticky cell per bit; set has priority over clear
    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)           status_q[i] <= 1'b0;
            else if (ev_set[i])   status_q[i] <= 1'b1;
            else if (stat_clr[i]) status_q[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    always_comb irq = |(status_q & mask_q);
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import isc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int HW_EV  = 8,
    parameter int TMR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [HW_EV-1:0]  hw_event,
    input  logic              sys_err,
    output logic              irq
);
    localparam int GAP_W = BIT_TIMEOUT - BIT_SWINT - 1;

    logic [STAT_W-1:0] status_q, mask_q, stat_clr, ev_set;
    logic [TMR_W-1:0]  cnt_q, cmp_q;
    logic mask_we, poll_sw, cnt_we, cmp_we, timeout_evt;

    isc_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMR_W(TMR_W)) regif_i (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .status_q (status_q),
        .mask_q   (mask_q),
        .cnt_q    (cnt_q),
        .cmp_q    (cmp_q),
        .stat_clr (stat_clr),
        .mask_we  (mask_we),
        .poll_sw  (poll_sw),
        .cnt_we   (cnt_we),
        .cmp_we   (cmp_we),
        .bus_rdata(bus_rdata)
    );

    isc_timer #(.TMR_W(TMR_W)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_we     (cnt_we),
        .cmp_we     (cmp_we),
        .cmp_wdata  (bus_wdata[TMR_W-1:0]),
        .cnt_q      (cnt_q),
        .cmp_q      (cmp_q),
        .timeout_evt(timeout_evt)
    );

    always_comb ev_set = {sys_err, timeout_evt, {GAP_W{1'b0}}, poll_sw, hw_event};

    isc_status status_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_set    (ev_set),
        .stat_clr  (stat_clr),
        .mask_we   (mask_we),
        .mask_wdata(bus_wdata[STAT_W-1:0]),
        .status_q  (status_q),
        .mask_q    (mask_q),
        .irq       (irq)
    );
endmodule

// File: rtl/isc_checker.sv
module isc_checker
    import isc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic [7:0]        hw_event,
    input logic              irq,
    input logic [STAT_W-1:0] status_q,
    input logic [STAT_W-1:0] mask_q,
    input logic [31:0]       cnt_q,
    input logic [31:0]       cmp_q
);
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_event[0] |=> status_q[0]); // R2
    AST_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[13:9] == 5'd0); // R2
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_STATUS && bus_wdata[1] && !hw_event[1]) |=> !status_q[1]); // R3
    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_STATUS && !bus_wdata[0] && status_q[0]) |=> status_q[0]); // R3
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_STATUS && bus_wdata[2] && hw_event[2]) |=> status_q[2]); // R4
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq); // R5
    AST_POLL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_POLL && bus_wdata[0]) |=> status_q[BIT_SWINT]); // R6
    AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_COUNT) |=> (cnt_q == 32'd0)); // R7
    AST_TIMEOUT_NEEDS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[BIT_TIMEOUT]) |-> ($past(cmp_q) != 32'd0)); // R9
endmodule

bind irq_status_ctrl isc_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .hw_event (hw_event),
    .irq      (irq),
    .status_q (status_q),
    .mask_q   (mask_q),
    .cnt_q    (cnt_q),
    .cmp_q    (cmp_q)
);

// File: tb/irq_status_ctrl_tb_top.sv
module irq_status_ctrl_tb_top;
    localparam logic [7:0] A_POLL = 8'h38, A_MASK = 8'h3C, A_STAT = 8'h3E,
                           A_CNT = 8'h48, A_CMP = 8'h58;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  hw_event = '0;
    logic        sys_err = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] st_m = '0;
    logic [15:0] mk_m = '0;

    always #2.5 clk = ~clk;

    irq_status_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_event(hw_event),
        .sys_err(sys_err), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] next_status(input logic [15:0] st, input logic [15:0] clr,
                                                input logic [15:0] ev);
        return (st & ~clr) | ev;
    endfunction

    function automatic logic irq_of(input logic [15:0] st, input logic [15:0] mk);
        return |(st & mk);
    endfunction

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    // one write cycle; events already on the inputs apply to the same edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; hw_event = '0; sys_err = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        rd(A_STAT, d); chk("R1 status", d, 0);
        rd(A_MASK, d); chk("R1 mask", d, 0);
        rd(A_CMP, d);  chk("R1 compare", d, 0);
        rd(A_CNT, d);  chk("R1 count", d, 0);
        chk("R1 irq", 32'(irq), 0);
        @(negedge clk); rst_n = 1'b1;

        // R2 events latch while masked; R5 no irq, then unmask raises it
        @(negedge clk); hw_event = 8'h81; sys_err = 1'b1;
        @(posedge clk); #1; hw_event = '0; sys_err = 1'b0;
        rd(A_STAT, d); chk("R2 event bits", d, 32'h8081);
        chk("R5 masked irq low", 32'(irq), 0);
        wr(A_MASK, 32'h0000_0080);
        chk("R5 unmask raises irq", 32'(irq), 1);
        rd(A_MASK, d); chk("R10 mask readback", d, 32'h80);

        // R3 write zero keeps, write one clears; reserved bits stay zero
        wr(A_STAT, 32'h0000_3E00);
        rd(A_STAT, d); chk("R3 write zero keeps / R2 gap bits", d, 32'h8081);
        wr(A_STAT, 32'h0000_0080);
        rd(A_STAT, d); chk("R3 write one clears", d, 32'h8001);
        chk("R5 irq drops after clear", 32'(irq), 0);

        // R4 event beats simultaneous clear
        hw_event = 8'h04;
        wr(A_STAT, 32'h0000_0004);
        rd(A_STAT, d); chk("R4 event wins", d, 32'h8005);

        // R6 poll
        wr(A_POLL, 32'h0000_0040);
        rd(A_STAT, d); chk("R6 poll bit0 clear ignored", d, 32'h8005);
        wr(A_POLL, 32'h0000_0001);
        rd(A_STAT, d); chk("R6 poll sets bit8", d, 32'h8105);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, d); chk("R3 clear all", d, 0);

        // R7 count
        wr(A_CNT, 32'hDEAD_BEEF);
        rd(A_CNT, d); chk("R7 count cleared", d, 0);
        repeat (7) @(posedge clk);
        #1; rd(A_CNT, d); chk("R7 count increments", d, 7);

        // R8 timeout exact cycle
        wr(A_CMP, 32'd10);
        rd(A_CMP, d); chk("R10 compare readback", d, 10);
        wr(A_MASK, 32'h0000_4000);
        wr(A_CNT, 32'd0);
        repeat (10) @(posedge clk);
        #1; rd(A_CNT, d); chk("R8 count at compare", d, 10);
        rd(A_STAT, d); chk("R8 not yet set", d, 0);
        @(posedge clk); #1;
        rd(A_STAT, d); chk("R8 timeout set", d, 32'h4000);
        chk("R8 irq from timeout", 32'(irq), 1);

        // R9 compare zero disables
        wr(A_CMP, 32'd0);
        wr(A_STAT, 32'h0000_4000);
        wr(A_CNT, 32'd0);
        repeat (30) @(posedge clk);
        #1; rd(A_STAT, d); chk("R9 no timeout with zero compare", d, 0);

        // random mix against the model (timer disabled)
        wr(A_MASK, 32'h0);
        st_m = '0; mk_m = '0;
        for (int i = 0; i < 400; i++) begin
            logic [7:0]  ev;
            logic        se;
            logic [31:0] wd;
            logic [1:0]  sel;
            logic        dowr;
            logic [15:0] clr, evv;
            ev   = 8'($urandom) & 8'($urandom) & 8'($urandom);
            se   = ($urandom % 8) == 0;
            wd   = $urandom;
            sel  = 2'($urandom % 3);
            dowr = ($urandom % 2) == 0;
            @(negedge clk);
            hw_event = ev; sys_err = se; bus_wdata = wd; bus_wr = dowr;
            bus_addr = (sel == 0) ? A_STAT : (sel == 1) ? A_MASK : A_POLL;
            clr = (dowr && sel == 0) ? wd[15:0] : 16'h0;
            evv = {se, 1'b0, 5'b0, (dowr && sel == 2 && wd[0]), ev};
            @(posedge clk);
            #1;
            bus_wr = 1'b0; hw_event = '0; sys_err = 1'b0;
            st_m = next_status(st_m, clr, evv);
            if (dowr && sel == 1) mk_m = wd[15:0];
            rd(A_STAT, d); chk("R2/R3/R4/R6 random status", d, 32'(st_m));
            chk("R5 random irq", 32'(irq), 32'(irq_of(st_m, mk_m)));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule